// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

This block gathers level-sensitive interrupt inputs from a parameterised number of sources and routes them to a small set of hart contexts. Each context gets its own interrupt line. Software works the block over a simple single-cycle register bus with 32-bit data. Through that bus it sets a priority for each source, an enable bitmap and a threshold for each context, and reads a bitmap of pending sources.

A gateway turns each rising input into a pending bit. A context services an interrupt in three steps. First it reads its claim register, which hands back the best eligible source and clears that source's pending bit. It then does its work. Last, it writes the source ID back to the same register to complete. If the input is still high when the completion is written, the source pends again at once.

Each context's output is derived combinationally from the register state. Any write to a priority, enable or threshold register therefore takes effect on the output in the cycle after the write. The source count must be a multiple of 32, and source 0 is reserved.

Top module: `plic_lite`

## Requirements
- R1: Priority of source s (1 ≤ s < NSRC) is read and written at byte address 4·s. Only the low 3 bits are stored, and the upper bits read as zero. Writes to source 0, or to an index at or above NSRC, are ignored, and those addresses read as 0.
- R2: The pending bitmap reads at 0x1000 + 4·w, where bit b is source 32·w + b. Writes to 0x1000–0x107F change nothing.
- R3: The enable bitmap for context c, word w, is at 0x2000 + 0x80·c + 4·w, with bit b enabling source 32·w + b. Accesses to a context ≥ NCTX or a word ≥ NSRC/32 are ignored and read as 0.
- R4: Context c's 3-bit threshold sits at 0x200000 + 0x1000·c, and its claim/complete register sits at offset 4 of that block.
- R5: irq_o[c] is 1 exactly when some source is pending, enabled for c, and has a priority strictly greater than c's threshold. A priority equal to the threshold does not interrupt. All outputs are 0 after reset.
- R6: A claim read returns the enabled, pending source with the highest nonzero priority, ignoring the threshold. Ties go to the lowest ID. The read returns 0 when there is no candidate.
- R7: A claim that returns a nonzero ID clears that source's pending bit and marks the source in service. An in-service source is never pending.
- R8: A write of an in-service ID to claim/complete ends service. The source pends again in the next cycle if its input is high at the time of the write, and stays idle if the input is low.
- R9: After a write to a priority, enable or threshold register, the interrupt outputs reflect the new value from the next cycle on, both asserting and dropping.
- R10: A 0→1 transition on an input sets the pending bit only if the source is neither pending nor in service. Source 0 never pends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NSRC | Level interrupt inputs; bit 0 is unused |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
Several rules are checked by assertions on every clock:
- a source is never both pending and in service;
- source 0 stays idle;
- a nonzero claim leaves its source in service in the following cycle;
- a raised output always has an enabled pending source behind it;
- the upper priority bits read back as zero.

Other behaviour shows up only in the bench's scenarios, where a behavioural model is compared against every output and every read. That covers the ordering rules of the claim (ties, the empty claim), the strict threshold boundary, re-arming on completion with the input held high, and suppression of rising edges while a source is in service.

// File: rtl/plic_lite.sv
module plic_lite #(
  parameter int NSRC   = 32,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int AW     = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_o
);
  localparam int IDW   = $clog2(NSRC);
  localparam int NWORD = NSRC / 32;
  localparam int CTXW  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam logic [AW-1:0] A_PEND = AW'(32'h1000);
  localparam logic [AW-1:0] A_PEND_END = AW'(32'h1080);
  localparam logic [AW-1:0] A_EN   = AW'(32'h2000);
  localparam logic [AW-1:0] A_CTX  = AW'(32'h200000);

  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   en   [NCTX];
  logic [PRIO_W-1:0] thr  [NCTX];
  logic [NSRC-1:0]   pend, busy, src_q, pend_n, busy_n;
  logic [PRIO_W-1:0] cand_pr [NCTX];
  logic [IDW-1:0]    cand_id [NCTX];

  logic rd_go, wr_go, in_prio, in_pend, in_en, in_ctx;
  logic prio_ok, pend_ok, en_ok, ctx_ok, is_thr, is_claim, claim_go, cmp_ok;
  logic [AW-1:0] en_off, ctx_off, pidx_a, ectx_a, cctx_a;
  logic [IDW-1:0] pidx, claim_id, cmp_id;
  logic [CTXW-1:0] ectx, cctx;
  logic [4:0] word;
  logic [11:0] creg;

  assign rd_go    = bus_en & ~bus_we;
  assign wr_go    = bus_en & bus_we;
  assign in_prio  = bus_addr < A_PEND;
  assign in_pend  = bus_addr >= A_PEND && bus_addr < A_PEND_END;
  assign in_en    = bus_addr >= A_EN && bus_addr < A_CTX;
  assign in_ctx   = bus_addr >= A_CTX;
  assign en_off   = bus_addr - A_EN;
  assign ctx_off  = bus_addr - A_CTX;
  assign pidx_a   = bus_addr >> 2;
  assign ectx_a   = en_off >> 7;
  assign cctx_a   = ctx_off >> 12;
  assign pidx     = pidx_a[IDW-1:0];
  assign ectx     = ectx_a[CTXW-1:0];
  assign cctx     = cctx_a[CTXW-1:0];
  assign word     = bus_addr[6:2];
  assign creg     = bus_addr[11:0];
  assign prio_ok  = in_prio && pidx_a != '0 && pidx_a < AW'(NSRC);
  assign pend_ok  = in_pend && word < 5'(NWORD);
  assign en_ok    = in_en && ectx_a < AW'(NCTX) && word < 5'(NWORD);
  assign ctx_ok   = in_ctx && cctx_a < AW'(NCTX);
  assign is_thr   = ctx_ok && creg == 12'h0;
  assign is_claim = ctx_ok && creg == 12'h4;

  // Ascending scan, strict compare: lowest ID wins a tie
  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      cand_pr[c] = '0;
      cand_id[c] = '0;
      for (int i = 1; i < NSRC; i++)
        if (pend[i] && en[c][i] && prio[i] > cand_pr[c]) begin
          cand_pr[c] = prio[i];
          cand_id[c] = IDW'(i);
        end
      irq_o[c] = cand_pr[c] > thr[c];
    end
  end

  assign claim_id = cand_id[cctx];
  assign claim_go = rd_go && is_claim && claim_id != '0;
  assign cmp_id   = bus_wdata[IDW-1:0];
  assign cmp_ok   = wr_go && is_claim && bus_wdata != 32'd0 &&
                    bus_wdata < 32'(NSRC) && busy[cmp_id];

  always_comb begin
    pend_n = pend | (src_i & ~src_q & ~busy);
    pend_n[0] = 1'b0;
    busy_n = busy;
    if (claim_go) begin
      pend_n[claim_id] = 1'b0;
      busy_n[claim_id] = 1'b1;
    end
    if (cmp_ok) begin
      busy_n[cmp_id] = 1'b0;
      if (src_i[cmp_id]) pend_n[cmp_id] = 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_go) begin
      if (prio_ok) bus_rdata = 32'(prio[pidx]);
      for (int w = 0; w < NWORD; w++) begin
        if (pend_ok && word == 5'(w)) bus_rdata = pend[w*32 +: 32];
        if (en_ok && word == 5'(w))   bus_rdata = en[ectx][w*32 +: 32];
      end
      if (is_thr)   bus_rdata = 32'(thr[cctx]);
      if (is_claim) bus_rdata = 32'(claim_id);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      busy  <= '0;
      src_q <= '0;
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else begin
      pend  <= pend_n;
      busy  <= busy_n;
      src_q <= src_i;
      if (wr_go && prio_ok) prio[pidx] <= bus_wdata[PRIO_W-1:0];
      if (wr_go && is_thr)  thr[cctx]  <= bus_wdata[PRIO_W-1:0];
      for (int w = 0; w < NWORD; w++)
        if (wr_go && en_ok && word == 5'(w)) en[ectx][w*32 +: 32] <= bus_wdata;
    end
  end

  AST_SERVICE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0); // R7
  AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !busy[0]); // R10
  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    claim_go |=> !pend[$past(claim_id)] && busy[$past(claim_id)]); // R7
  AST_PRIO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && in_prio) |-> bus_rdata[31:PRIO_W] == '0); // R1

  for (genvar g = 0; g < NCTX; g++) begin : g_irq_chk
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> (pend & en[g]) != '0); // R5
  end
endmodule

// File: tb/plic_lite_test.sv
module plic_lite_test;
  localparam int NSRC = 32;
  localparam int NCTX = 2;
  localparam int AW   = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCTX-1:0] irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  plic_lite #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  // Behavioural reference model
  int m_prio [NSRC];
  int m_thr [NCTX];
  bit [31:0] m_en [NCTX];
  bit [31:0] m_pend, m_busy, m_srcq;

  function automatic int m_cand(int c);
    int best = 0, id = 0;
    for (int i = 1; i < NSRC; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > best) begin best = m_prio[i]; id = i; end
    return id;
  endfunction

  function automatic bit m_irq(int c);
    for (int i = 1; i < NSRC; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > m_thr[c]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_read(int a);
    int c, w, r;
    if (a < 'h1000) begin
      w = a >> 2;
      return (w > 0 && w < NSRC) ? m_prio[w] : 0;
    end else if (a < 'h1080) begin
      w = (a - 'h1000) >> 2;
      return (w == 0) ? int'(m_pend) : 0;
    end else if (a < 'h2000) return 0;
    else if (a < 'h200000) begin
      c = (a - 'h2000) >> 7; w = ((a - 'h2000) >> 2) & 31;
      return (c < NCTX && w == 0) ? int'(m_en[c]) : 0;
    end else begin
      c = (a - 'h200000) >> 12; r = (a - 'h200000) & 'hFFF;
      if (c >= NCTX) return 0;
      if (r == 0) return m_thr[c];
      if (r == 4) return m_cand(c);
      return 0;
    end
  endfunction

  always @(posedge clk) begin
    int a, c, r, id;
    bit [31:0] rise;
    if (!rst_n) begin
      m_pend = 0; m_busy = 0; m_srcq = 0;
      for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
      for (int k = 0; k < NCTX; k++) begin m_en[k] = 0; m_thr[k] = 0; end
    end else begin
      rise = src_i & ~m_srcq & ~m_busy;
      rise[0] = 1'b0;
      m_pend |= rise;
      a = int'(bus_addr);
      c = (a - 'h200000) >> 12; r = (a - 'h200000) & 'hFFF;
      if (bus_en && !bus_we && a >= 'h200000 && c < NCTX && r == 4) begin
        id = m_cand(c);
        if (id != 0) begin m_pend[id] = 1'b0; m_busy[id] = 1'b1; end
      end
      if (bus_en && bus_we) begin
        if (a < 'h1000 && (a >> 2) > 0 && (a >> 2) < NSRC) m_prio[a >> 2] = bus_wdata & 7;
        else if (a >= 'h2000 && a < 'h200000 && ((a - 'h2000) >> 7) < NCTX &&
                 (((a - 'h2000) >> 2) & 31) == 0) m_en[(a - 'h2000) >> 7] = bus_wdata;
        else if (a >= 'h200000 && c < NCTX && r == 0) m_thr[c] = bus_wdata & 7;
        else if (a >= 'h200000 && c < NCTX && r == 4) begin
          if (bus_wdata >= 1 && bus_wdata < NSRC && m_busy[bus_wdata]) begin
            m_busy[bus_wdata] = 1'b0;
            if (src_i[bus_wdata]) m_pend[bus_wdata] = 1'b1;
          end
        end
      end
      m_srcq = src_i;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R5, R6 and every readable field)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NCTX; k++) chk("R5 model irq", 32'(irq_o[k]), 32'(m_irq(k)));
      if (bus_en && !bus_we) chk("R1-R6 model read", bus_rdata, 32'(m_read(int'(bus_addr))));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    bus_en = 1; bus_we = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); #2;
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_en = 1; bus_we = 0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(posedge clk); #2;
    bus_en = 0;
  endtask

  task automatic set_src(input logic [31:0] v);
    src_i = v;
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    chk("R5 reset irq", 32'(irq_o), 0);
    rd('h1000, rv); chk("R2 reset pending", rv, 0);

    wr(4, 32'hFF); rd(4, rv); chk("R1 prio width", rv, 7);
    wr(0, 5); rd(0, rv); chk("R1 source0 ignored", rv, 0);
    wr('h80, 3); rd('h80, rv); chk("R1 out of range", rv, 0);

    wr(12, 5); wr(20, 5); wr(28, 2); wr(36, 4);
    wr('h2000, 32'h2A8); wr('h200000, 0);
    wr('h2080, 32'h200); wr('h201000, 4);
    rd('h2080, rv); chk("R3 enable ctx1", rv, 32'h200);
    rd('h201000, rv); chk("R4 threshold ctx1", rv, 4);

    set_src(32'h2A8);
    rd('h1000, rv); chk("R10 rising sets pending", rv, 32'h2A8);
    chk("R5 ctx0 asserted", 32'(irq_o[0]), 1);
    chk("R5 prio equal threshold", 32'(irq_o[1]), 0);
    wr('h201000, 3); chk("R9 lower threshold asserts", 32'(irq_o[1]), 1);
    wr('h201000, 4); chk("R9 raise threshold drops", 32'(irq_o[1]), 0);

    wr('h1000, 0); rd('h1000, rv); chk("R2 pending write ignored", rv, 32'h2A8);

    rd('h201004, rv); chk("R6 ctx1 prio not above 0? picks 9", rv, 9);
    wr('h201004, 9);
    rd('h1000, rv); chk("R8 complete with input high", rv, 32'h2A8);

    rd('h200004, rv); chk("R6 tie lowest id", rv, 3);
    rd('h1000, rv); chk("R7 claim clears", rv, 32'h2A0);
    rd('h200004, rv); chk("R6 next tie", rv, 5);
    rd('h200004, rv); chk("R6 priority order", rv, 9);
    rd('h200004, rv); chk("R6 lowest priority last", rv, 7);
    rd('h200004, rv); chk("R6 empty claim", rv, 0);
    chk("R5 nothing pending", 32'(irq_o), 0);

    set_src(32'h2A0); set_src(32'h2A8);
    rd('h1000, rv); chk("R10 rise ignored in service", rv, 0);

    wr('h200004, 3);
    rd('h1000, rv); chk("R8 re-arm input high", rv, 32'h8);
    set_src(32'h288);
    wr('h200004, 5);
    rd('h1000, rv); chk("R8 input low stays idle", rv, 32'h8);
    wr('h200004, 5);
    rd('h1000, rv); chk("R8 complete not in service ignored", rv, 32'h8);

    wr('h2000, 0); chk("R9 enable clear drops", 32'(irq_o[0]), 0);
    wr('h2000, 32'h8); chk("R9 enable set asserts", 32'(irq_o[0]), 1);
    wr('h2100, 32'hFFFF); rd('h2100, rv); chk("R3 context out of range", rv, 0);
    wr('h2004, 32'hFFFF); rd('h2004, rv); chk("R3 word out of range", rv, 0);
    rd('h201004, rv); chk("R6 not enabled in ctx1", rv, 0);

    wr('h200000, 32'hFFFFFFFF); rd('h200000, rv); chk("R4 threshold width", rv, 7);
    chk("R5 below threshold", 32'(irq_o[0]), 0);
    wr('h200000, 5); chk("R5 equal threshold", 32'(irq_o[0]), 0);
    wr('h200000, 4); chk("R9 threshold drop asserts", 32'(irq_o[0]), 1);
    wr(12, 1); chk("R9 prio write drops", 32'(irq_o[0]), 0);
    wr(12, 6); chk("R9 prio write asserts", 32'(irq_o[0]), 1);

    set_src(32'h289);
    rd('h1000, rv); chk("R10 source0 never pends", rv, 32'h8);
    wr('h200004, 32'h40);
    rd('h1000, rv); chk("R8 bad id ignored", rv, 32'h8);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule